// File: doc/BRIEF.md
# Two-Channel Time-Division Link Transmitter

This block drives one serial link that carries two logical channels interleaved bit by bit. The control channel carries short 6-bit protected symbols for triggers, frame headers and synchronization commands. The data channel carries the bits of frames. A scheduler chooses the next control symbol by priority. The interleaver then places control bits in even link slots and frame bits in odd link slots.

The block runs on a clock at sixteen times the reference rate. A rate selector sets how often a link bit is produced: 4, 8 or 16 times the reference rate. Each new bit appears on `ser_o` with a one-cycle `bit_en_o` pulse. A frame source raises a one-cycle request and presents its 16-bit words on a parallel port. The block announces the frame with a header symbol, then pulls each word with `frm_rd_o` and shifts it out.

Top module: `lnk_tdm_tx`

## Requirements
- R1: `rate_sel_i` = 0 gives one `bit_en_o` pulse every 4 clocks, 1 gives one every 2 clocks, and 2 or 3 gives one every clock.
- R2: Link slots alternate strictly, starting after reset with a control slot. Even slots carry control-symbol bits and odd slots carry frame bits, so one symbol spans 12 slots. Symbols are sent MSB first. The first `bit_en_o` pulse comes in the first clock after reset is released.
- R3: Symbol codes are: idle 000000, trigger 111000, header 000111, sync 110011.
- R4: With nothing pending, the idle symbol is sent. Every frame slot outside a frame carries 0.
- R5: A new symbol is chosen only at a symbol boundary. The priority order is trigger, then header, then sync.
- R6: A trigger strobe is held in a one-deep pending flag. A strobe that arrives while a trigger is pending, and that flag is not being taken in that clock, is discarded. `trig_ovf_o` then pulses for one clock, one clock after that strobe.
- R7: Each frame is preceded by one header symbol. The frame's first bit goes out in the frame slot right after the header's last bit. Words are sent MSB first and back to back, and the frame ends after the word that was flagged last.
- R8: `frm_rd_o` is a one-clock pulse in the clock whose edge takes `frm_word_i` and `frm_last_i`. There is one pulse per word. The next link bit follows in the next clock.
- R9: No header symbol starts while a frame is being sent. A frame request made during a frame waits until that frame ends.
- R10: While reset is held, `ser_o`, `bit_en_o`, `frm_rd_o` and `trig_ovf_o` are 0.
- R11: Sync strobes merge while one is pending: several strobes before the next boundary yield one sync symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 16 times the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel_i | input | 2 | Link rate select: 0 = 4x, 1 = 8x, 2 or 3 = 16x |
| trig_i | input | 1 | One-clock trigger strobe |
| sync_i | input | 1 | One-clock sync-command strobe |
| frm_req_i | input | 1 | One-clock strobe: a frame is ready; repeats while one is pending merge |
| frm_word_i | input | WORD_W | Current frame word, valid while a frame is ready |
| frm_last_i | input | 1 | Marks `frm_word_i` as the last word of its frame |
| frm_rd_o | output | 1 | Word taken at this clock edge |
| ser_o | output | 1 | Serial link bit |
| bit_en_o | output | 1 | One-clock pulse: `ser_o` holds a new link bit |
| trig_ovf_o | output | 1 | One-clock pulse: a trigger was dropped |

## Verification
The assertions watch properties that hold in every clock. At rates below 16x, no two bit pulses come back to back. Every overflow pulse follows a strobe that met a pending trigger. A trigger pending at a boundary is always the symbol chosen. A frame only becomes active straight after a header symbol, and every word read is followed by a link bit. The bench scenarios cover what needs the stream decoded over many slots. These are the exact symbol codes and their order under simultaneous requests, bit-exact frame contents and their alignment to the header, a second frame held back until the first ends, the exact number of dropped triggers, the merging of sync strobes, and the pulse spacing at each rate.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    localparam int SYM_W     = 6;
    localparam int SYM_IDX_W = $clog2(SYM_W);

    typedef enum logic [1:0] {
        K_IDLE = 2'd0,
        K_TRIG = 2'd1,
        K_HDR  = 2'd2,
        K_SYNC = 2'd3
    } sym_kind_e;

    typedef enum logic {
        SL_THS = 1'b0,
        SL_FRM = 1'b1
    } slot_e;

    localparam logic [SYM_W-1:0] C_IDLE = 6'b000000;
    localparam logic [SYM_W-1:0] C_TRIG = 6'b111000;
    localparam logic [SYM_W-1:0] C_HDR  = 6'b000111;
    localparam logic [SYM_W-1:0] C_SYNC = 6'b110011;

    localparam logic [1:0] RATE_4X  = 2'd0;
    localparam logic [1:0] RATE_8X  = 2'd1;

    function automatic logic [SYM_W-1:0] code_of(input sym_kind_e k);
        case (k)
            K_TRIG:  return C_TRIG;
            K_HDR:   return C_HDR;
            K_SYNC:  return C_SYNC;
            default: return C_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/lnk_rate_gen.sv
module lnk_rate_gen
    import lnk_pkg::*;
#(
    parameter int MAX_MULT = 16,
    parameter int MIN_MULT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           rate_sel_i,
    output logic                 tick_o,
    output slot_e                slot_o,
    output logic [SYM_IDX_W-1:0] idx_o,
    output logic                 sym_start_o
);

    localparam int DIV_MAX = MAX_MULT / MIN_MULT;
    localparam int DIV_W   = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;
    localparam logic [DIV_W-1:0] RL_4X = DIV_W'(DIV_MAX - 1);
    localparam logic [DIV_W-1:0] RL_8X = DIV_W'((DIV_MAX / 2 > 0) ? DIV_MAX / 2 - 1 : 0);
    localparam logic [SYM_IDX_W-1:0] LAST_IDX = SYM_IDX_W'(SYM_W - 1);

    typedef struct packed {
        logic [DIV_W-1:0]     div;
        slot_e                slot;
        logic [SYM_IDX_W-1:0] idx;
    } rg_t;

    rg_t              s_d, s_q;
    logic [DIV_W-1:0] reload;
    logic             tick;

    always_comb begin
        s_d = s_q;
        case (rate_sel_i)
            RATE_4X: reload = RL_4X;
            RATE_8X: reload = RL_8X;
            default: reload = '0;
        endcase
        tick = (s_q.div == '0);
        if (tick) begin
            s_d.div = reload;
            if (s_q.slot == SL_THS) begin
                s_d.slot = SL_FRM;
            end else begin
                s_d.slot = SL_THS;
                s_d.idx  = (s_q.idx == LAST_IDX) ? '0 : s_q.idx + 1'b1;
            end
        end else begin
            s_d.div = s_q.div - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{div: '0, slot: SL_THS, idx: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o      = tick;
    assign slot_o      = s_q.slot;
    assign idx_o       = s_q.idx;
    assign sym_start_o = tick && (s_q.slot == SL_THS) && (s_q.idx == '0);

endmodule

// File: rtl/lnk_ths_sched.sv
module lnk_ths_sched
    import lnk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_i,
    input  logic                 frm_req_i,
    input  logic                 sync_i,
    input  logic                 tick_i,
    input  slot_e                slot_i,
    input  logic [SYM_IDX_W-1:0] idx_i,
    input  logic                 sym_start_i,
    input  logic                 frm_busy_i,
    output logic                 ths_bit_o,
    output logic                 frm_go_o,
    output logic                 trig_ovf_o,
    output logic                 trig_pend_o,
    output sym_kind_e            cur_kind_o
);

    localparam logic [SYM_IDX_W-1:0] LAST_IDX = SYM_IDX_W'(SYM_W - 1);

    typedef struct packed {
        logic      trig_pend;
        logic      hdr_pend;
        logic      sync_pend;
        logic      ovf;
        sym_kind_e cur;
    } sch_t;

    sch_t                 s_d, s_q;
    sym_kind_e            pick;
    logic                 take_trig, take_hdr, take_sync;
    logic [SYM_W-1:0]     sym;
    logic [SYM_IDX_W-1:0] pos;

    always_comb begin
        take_trig = 1'b0;
        take_hdr  = 1'b0;
        take_sync = 1'b0;
        pick      = K_IDLE;
        if (s_q.trig_pend) begin
            pick      = K_TRIG;
            take_trig = sym_start_i;
        end else if (s_q.hdr_pend && !frm_busy_i) begin
            pick     = K_HDR;
            take_hdr = sym_start_i;
        end else if (s_q.sync_pend) begin
            pick      = K_SYNC;
            take_sync = sym_start_i;
        end

        s_d           = s_q;
        s_d.trig_pend = trig_i || (s_q.trig_pend && !take_trig);
        s_d.ovf       = trig_i && s_q.trig_pend && !take_trig;
        s_d.hdr_pend  = frm_req_i || (s_q.hdr_pend && !take_hdr);
        s_d.sync_pend = sync_i || (s_q.sync_pend && !take_sync);
        if (sym_start_i) begin
            s_d.cur = pick;
        end

        sym       = sym_start_i ? code_of(pick) : code_of(s_q.cur);
        pos       = LAST_IDX - idx_i;
        ths_bit_o = sym[pos];
        frm_go_o  = tick_i && (slot_i == SL_THS) && (idx_i == LAST_IDX) &&
                    (s_q.cur == K_HDR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{trig_pend: 1'b0, hdr_pend: 1'b0, sync_pend: 1'b0,
                     ovf: 1'b0, cur: K_IDLE};
        end else begin
            s_q <= s_d;
        end
    end

    assign trig_ovf_o  = s_q.ovf;
    assign trig_pend_o = s_q.trig_pend;
    assign cur_kind_o  = s_q.cur;

endmodule

// File: rtl/lnk_frm_ser.sv
module lnk_frm_ser #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_tick_i,
    input  logic              frm_go_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              last_i,
    output logic              rd_o,
    output logic              bit_o,
    output logic              active_o
);

    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic              active;
        logic              last;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sr;
    } fs_t;

    fs_t  s_d, s_q;
    logic word_end;

    always_comb begin
        s_d      = s_q;
        word_end = s_q.active && (s_q.cnt == CNT_END);
        rd_o     = frm_go_i || (frm_tick_i && word_end && !s_q.last);
        if (frm_go_i) begin
            s_d.active = 1'b1;
            s_d.sr     = word_i;
            s_d.last   = last_i;
            s_d.cnt    = '0;
        end else if (frm_tick_i && s_q.active) begin
            if (word_end) begin
                if (s_q.last) begin
                    s_d.active = 1'b0;
                    s_d.sr     = '0;
                end else begin
                    s_d.sr   = word_i;
                    s_d.last = last_i;
                end
                s_d.cnt = '0;
            end else begin
                s_d.sr  = {s_q.sr[WORD_W-2:0], 1'b0};
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_o    = s_q.active ? s_q.sr[WORD_W-1] : 1'b0;
    assign active_o = s_q.active;

endmodule

// File: rtl/lnk_tdm_tx.sv
module lnk_tdm_tx
    import lnk_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int MAX_MULT = 16,
    parameter int MIN_MULT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate_sel_i,
    input  logic              trig_i,
    input  logic              sync_i,
    input  logic              frm_req_i,
    input  logic [WORD_W-1:0] frm_word_i,
    input  logic              frm_last_i,
    output logic              frm_rd_o,
    output logic              ser_o,
    output logic              bit_en_o,
    output logic              trig_ovf_o
);

    typedef struct packed {
        logic ser;
        logic en;
    } out_t;

    logic                 tick;
    slot_e                slot;
    logic [SYM_IDX_W-1:0] idx;
    logic                 sym_start;
    logic                 ths_bit;
    logic                 frm_bit;
    logic                 frm_go;
    logic                 frm_active;
    logic                 trig_pend;
    sym_kind_e            cur_kind;
    out_t                 o_d, o_q;

    lnk_rate_gen #(
        .MAX_MULT (MAX_MULT),
        .MIN_MULT (MIN_MULT)
    ) u_rate (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_sel_i  (rate_sel_i),
        .tick_o      (tick),
        .slot_o      (slot),
        .idx_o       (idx),
        .sym_start_o (sym_start)
    );

    lnk_ths_sched u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig_i),
        .frm_req_i   (frm_req_i),
        .sync_i      (sync_i),
        .tick_i      (tick),
        .slot_i      (slot),
        .idx_i       (idx),
        .sym_start_i (sym_start),
        .frm_busy_i  (frm_active),
        .ths_bit_o   (ths_bit),
        .frm_go_o    (frm_go),
        .trig_ovf_o  (trig_ovf_o),
        .trig_pend_o (trig_pend),
        .cur_kind_o  (cur_kind)
    );

    lnk_frm_ser #(
        .WORD_W (WORD_W)
    ) u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_tick_i (tick && (slot == SL_FRM)),
        .frm_go_i   (frm_go),
        .word_i     (frm_word_i),
        .last_i     (frm_last_i),
        .rd_o       (frm_rd_o),
        .bit_o      (frm_bit),
        .active_o   (frm_active)
    );

    always_comb begin
        o_d    = o_q;
        o_d.en = tick;
        if (tick) begin
            o_d.ser = (slot == SL_THS) ? ths_bit : frm_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign ser_o    = o_q.ser;
    assign bit_en_o = o_q.en;

endmodule

// File: rtl/lnk_tdm_tx_chk.sv
module lnk_tdm_tx_chk
    import lnk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] rate_sel_i,
    input logic       bit_en_o,
    input logic       frm_rd_o,
    input logic       trig_i,
    input logic       trig_ovf_o,
    input logic       trig_pend,
    input logic       sym_start,
    input sym_kind_e  cur_kind,
    input logic       frm_active
);

    // R1: below 16x no two bit pulses are adjacent
    a_r1_no_adjacent_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en_o && ($past(rate_sel_i) == 2'd0 || $past(rate_sel_i) == 2'd1))
        |=> !bit_en_o);

    // R5: a pending trigger wins the boundary
    a_r5_trigger_first: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_start && trig_pend) |=> (cur_kind == K_TRIG));

    // R6: a drop pulse follows a strobe that met a pending trigger
    a_r6_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ovf_o |-> ($past(trig_i) && $past(trig_pend)));

    // R7: a frame only starts right after a header symbol
    a_r7_frame_after_header: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_active) |-> ($past(cur_kind) == K_HDR));

    // R8: every word read is followed by a link bit
    a_r8_read_then_bit: assert property (@(posedge clk) disable iff (!rst_n)
        frm_rd_o |=> bit_en_o);

endmodule

bind lnk_tdm_tx lnk_tdm_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_sel_i (rate_sel_i),
    .bit_en_o   (bit_en_o),
    .frm_rd_o   (frm_rd_o),
    .trig_i     (trig_i),
    .trig_ovf_o (trig_ovf_o),
    .trig_pend  (trig_pend),
    .sym_start  (sym_start),
    .cur_kind   (cur_kind),
    .frm_active (frm_active)
);

// File: tb/sim_lnk_tdm_tx.sv
module sim_lnk_tdm_tx;

    localparam logic [5:0] T_TRIG = 6'b111000;
    localparam logic [5:0] T_HDR  = 6'b000111;
    localparam logic [5:0] T_SYNC = 6'b110011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rate_sel_i = 2'd2;
    logic        trig_i = 1'b0;
    logic        sync_i = 1'b0;
    logic        frm_req_i = 1'b0;
    logic [15:0] frm_word_i = '0;
    logic        frm_last_i = 1'b0;
    logic        frm_rd_o, ser_o, bit_en_o, trig_ovf_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [5:0]  exp_sym[$];
    string       exp_tag[$];
    logic [16:0] exp_word[$];
    logic [16:0] src[$];

    event ev_sym_end;
    int   ovf_cnt = 0;

    always #10 clk = ~clk;

    lnk_tdm_tx u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel_i (rate_sel_i),
        .trig_i     (trig_i),
        .sync_i     (sync_i),
        .frm_req_i  (frm_req_i),
        .frm_word_i (frm_word_i),
        .frm_last_i (frm_last_i),
        .frm_rd_o   (frm_rd_o),
        .ser_o      (ser_o),
        .bit_en_o   (bit_en_o),
        .trig_ovf_o (trig_ovf_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_sym(input logic [5:0] c, input string tag);
        exp_sym.push_back(c);
        exp_tag.push_back(tag);
    endtask

    task automatic add_word(input logic [15:0] w, input logic last);
        src.push_back({last, w});
        exp_word.push_back({last, w});
    endtask

    task automatic pulse(input logic t, input logic f, input logic s);
        trig_i = t; frm_req_i = f; sync_i = s;
        @(negedge clk);
        trig_i = 1'b0; frm_req_i = 1'b0; sync_i = 1'b0;
    endtask

    task automatic rate_chk(input logic [1:0] sel, input int exp_cnt);
        int cnt;
        rate_sel_i = sel;
        repeat (16) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (bit_en_o) cnt++;
        end
        chk(cnt == exp_cnt, "R1", "bit pulses in 32 clocks", cnt, exp_cnt);
    endtask

    // word source: advance after the edge that took a word
    bit adv = 1'b0;
    always @(negedge clk) begin
        if (adv && src.size() > 0) void'(src.pop_front());
        adv = frm_rd_o;
        if (frm_rd_o) chk(src.size() > 0, "R8", "read with a word available", 0, 1);
        frm_word_i = (src.size() > 0) ? src[0][15:0] : 16'h0;
        frm_last_i = (src.size() > 0) ? src[0][16] : 1'b0;
    end

    // monitor: decode the link stream and compare
    int         mslot = 0;
    logic [5:0] ths_sh = '0;
    bit         start_frame = 1'b0;
    bit         in_frame = 1'b0;
    int         wcnt = 0;
    logic [15:0] wsh = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mslot = 0; start_frame = 0; in_frame = 0; wcnt = 0;
        end else begin
            if (trig_ovf_o) ovf_cnt++;
            if (bit_en_o) begin
                if (mslot % 2 == 0) begin
                    ths_sh = {ths_sh[4:0], ser_o};
                    if (mslot == 10 && ths_sh != 6'b0) begin
                        if (ths_sh != T_TRIG && ths_sh != T_HDR && ths_sh != T_SYNC) begin
                            chk(1'b0, "R3", "unknown symbol", int'(ths_sh), 0);
                        end else if (exp_sym.size() == 0) begin
                            chk(1'b0, "R4", "unexpected symbol", int'(ths_sh), 0);
                        end else begin
                            logic [5:0] e;
                            string t;
                            e = exp_sym.pop_front();
                            t = exp_tag.pop_front();
                            chk(ths_sh == e, t, "symbol", int'(ths_sh), int'(e));
                        end
                        if (ths_sh == T_HDR) begin
                            chk(!in_frame, "R9", "header outside a frame", int'(in_frame), 0);
                            start_frame = 1'b1;
                        end
                    end
                end else begin
                    if (start_frame) begin
                        in_frame = 1'b1; start_frame = 1'b0; wcnt = 0;
                    end
                    if (in_frame) begin
                        wsh = {wsh[14:0], ser_o};
                        wcnt++;
                        if (wcnt == 16) begin
                            wcnt = 0;
                            if (exp_word.size() == 0) begin
                                chk(1'b0, "R7", "unexpected frame word", int'(wsh), 0);
                                in_frame = 1'b0;
                            end else begin
                                logic [16:0] ew;
                                ew = exp_word.pop_front();
                                chk(wsh == ew[15:0], "R7", "frame word", int'(wsh), int'(ew[15:0]));
                                if (ew[16]) in_frame = 1'b0;
                            end
                        end
                    end else begin
                        chk(ser_o == 1'b0, "R4", "idle frame slot", int'(ser_o), 0);
                    end
                    if (mslot == 11) -> ev_sym_end;
                end
                mslot = (mslot == 11) ? 0 : mslot + 1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        chk(ser_o == 0, "R10", "ser_o in reset", int'(ser_o), 0);
        chk(bit_en_o == 0, "R10", "bit_en_o in reset", int'(bit_en_o), 0);
        chk(frm_rd_o == 0, "R10", "frm_rd_o in reset", int'(frm_rd_o), 0);
        chk(trig_ovf_o == 0, "R10", "trig_ovf_o in reset", int'(trig_ovf_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bit_en_o == 1, "R2", "first link bit right after reset", int'(bit_en_o), 1);
        repeat (48) @(negedge clk);

        // single trigger
        push_sym(T_TRIG, "R3");
        pulse(1, 0, 0);
        repeat (30) @(negedge clk);

        // two-word frame
        push_sym(T_HDR, "R7");
        add_word(16'hA5C3, 1'b0);
        add_word(16'h0F81, 1'b1);
        pulse(0, 1, 0);
        repeat (100) @(negedge clk);

        // all three at once: priority order
        push_sym(T_TRIG, "R5");
        push_sym(T_HDR, "R5");
        push_sym(T_SYNC, "R5");
        add_word(16'h8001, 1'b1);
        pulse(1, 1, 1);
        repeat (120) @(negedge clk);

        // second frame requested during the first
        push_sym(T_HDR, "R9");
        add_word(16'h1234, 1'b0);
        add_word(16'hFFFF, 1'b0);
        add_word(16'h8421, 1'b1);
        pulse(0, 1, 0);
        repeat (30) @(negedge clk);
        push_sym(T_TRIG, "R9");
        push_sym(T_HDR, "R9");
        add_word(16'h7E5A, 1'b1);
        pulse(1, 1, 0);
        repeat (220) @(negedge clk);

        // sync strobes merge before one boundary
        @(ev_sym_end);
        push_sym(T_SYNC, "R11");
        pulse(0, 0, 1);
        @(negedge clk);
        pulse(0, 0, 1);
        @(negedge clk);
        pulse(0, 0, 1);
        repeat (40) @(negedge clk);

        // trigger overflow at 4x
        rate_sel_i = 2'd0;
        repeat (60) @(negedge clk);
        base = ovf_cnt;
        @(ev_sym_end);
        push_sym(T_TRIG, "R6");
        push_sym(T_TRIG, "R6");
        pulse(1, 0, 0);
        repeat (7) @(negedge clk);
        pulse(1, 0, 0);
        repeat (7) @(negedge clk);
        pulse(1, 0, 0);
        repeat (250) @(negedge clk);
        chk(ovf_cnt - base == 1, "R6", "dropped triggers", ovf_cnt - base, 1);

        // link rates
        rate_chk(2'd0, 8);
        rate_chk(2'd1, 16);
        rate_chk(2'd2, 32);
        repeat (100) @(negedge clk);

        chk(exp_sym.size() == 0, "R5", "symbols left unsent", exp_sym.size(), 0);
        chk(exp_word.size() == 0, "R7", "words left unsent", exp_word.size(), 0);
        chk(!in_frame, "R7", "frame closed", int'(in_frame), 0);

        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule